// File: doc/BRIEF.md
# IDE DMA Request Handshake Controller

This block produces the DMA request line that an IDE host controller presents to the system DMA engine. It supports multi-word DMA and Ultra DMA, each in both directions. The inputs are the selected mode and direction, the already-decoded bus strobes that write the outbound FIFO and read the inbound FIFO, and the occupancy counts of both FIFOs. Each transfer kind has its own rule for lowering the request.

In multi-word DMA, every bus access pulls the request low on the following bus clock cycle. In Ultra DMA write, the outbound FIFO fill level alone decides the request. In Ultra DMA read, the request is dropped after a burst of four bus reads, or as soon as the inbound FIFO is empty. The empty case covers the tail of a transfer whose length is not a multiple of four words.

The request is a single register. Every rule therefore takes effect on the clock edge after the inputs that trigger it.

Top module: `ide_dreq`

## Requirements
- R1: While `rst_ni` is low, or in any cycle after an edge where `en_i` was sampled low, `req_o` is 0. Disabling also clears the Ultra DMA read burst count.
- R2: Multi-word write (`mode_i`=0, `dir_i`=1): a cycle with `bus_wr_i`=1 makes `req_o` 0 after the next edge. Otherwise `req_o` becomes 1 exactly when `wr_cnt_i` < FIFO_DEPTH (8).
- R3: Multi-word read (`mode_i`=0, `dir_i`=0): a cycle with `bus_rd_i`=1 makes `req_o` 0 after the next edge. Otherwise `req_o` becomes 1 exactly when `rd_cnt_i` != 0.
- R4: Ultra DMA write (`mode_i`=1, `dir_i`=1): after each edge, `req_o` is 1 exactly when `wr_cnt_i` was below 4. `bus_wr_i` has no effect.
- R5: Ultra DMA read (`mode_i`=1, `dir_i`=0): the fourth bus read counted while `req_o` is 1 makes `req_o` 0 after the next edge.
- R6: Ultra DMA read: a cycle with `rd_cnt_i`=0 makes `req_o` 0 after the next edge, whatever the burst count.
- R7: Ultra DMA read: `req_o` rises only from a cycle with `rd_cnt_i` != 0. The read count restarts at zero whenever `req_o` rises, so a new run of four reads is needed.
- R8: When {`mode_i`,`dir_i`} differs from the value sampled on the previous edge, `req_o` is 0 after the next edge and the burst count is cleared. The value held at reset is {0,0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | DMA enable |
| mode_i | input | 1 | 0 = multi-word DMA, 1 = Ultra DMA |
| dir_i | input | 1 | 0 = device to memory (bus reads), 1 = memory to device (bus writes) |
| bus_wr_i | input | 1 | Decoded bus write to the outbound FIFO |
| bus_rd_i | input | 1 | Decoded bus read from the inbound FIFO |
| wr_cnt_i | input | CNT_W (4) | Outbound FIFO occupancy |
| rd_cnt_i | input | CNT_W (4) | Inbound FIFO occupancy |
| req_o | output | 1 | DMA request to the system DMA engine |

## Verification
The hardest case to reach is the restart of the Ultra DMA read burst count. The count is internal, so it can only be seen through the number of reads that `req_o` tolerates before it falls. The stimulus first leaves a partial burst of three reads behind. It then empties the inbound FIFO to force an early drop, refills the FIFO so the request rises again, and issues three more reads. The request must stay high through those reads and fall only on a fourth. The same pattern is repeated across a disable.

// File: rtl/ide_dreq_pkg.sv
package ide_dreq_pkg;
  // {mode, dir}
  typedef enum logic [1:0] {
    SEL_MW_RD = 2'b00,
    SEL_MW_WR = 2'b01,
    SEL_UD_RD = 2'b10,
    SEL_UD_WR = 2'b11
  } xfer_sel_e;
endpackage

// File: rtl/ide_dreq_cfg_trk.sv
module ide_dreq_cfg_trk
  import ide_dreq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      mode_i,
  input  logic      dir_i,
  output xfer_sel_e sel_o,
  output logic      chg_o
);
  xfer_sel_e sel_q;

  assign sel_o = xfer_sel_e'({mode_i, dir_i});
  assign chg_o = (sel_o != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SEL_MW_RD;
    else         sel_q <= sel_o;
  end
endmodule

// File: rtl/ide_dreq_burst.sv
module ide_dreq_burst #(
  parameter int unsigned BURST = 4,
  localparam int unsigned BW   = $clog2(BURST + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam logic [BW-1:0] LAST_C = BW'(BURST - 1);
  logic [BW-1:0] cnt_q;

  assign last_o = (cnt_q == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ide_dreq_rules.sv
module ide_dreq_rules
  import ide_dreq_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned WR_THRESH = 4
) (
  input  xfer_sel_e         sel_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [CNT_W-1:0]  wr_cnt_i,
  input  logic [CNT_W-1:0]  rd_cnt_i,
  input  logic              req_q_i,
  input  logic              burst_last_i,
  output logic              req_n_o,
  output logic              burst_inc_o
);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] THRESH_C = CNT_W'(WR_THRESH);

  logic rd_avail, wr_room;
  assign rd_avail = (rd_cnt_i != '0);
  assign wr_room  = (wr_cnt_i < DEPTH_C);

  always_comb begin
    req_n_o     = 1'b0;
    burst_inc_o = 1'b0;
    unique case (sel_i)
      SEL_MW_WR: req_n_o = !bus_wr_i && wr_room;
      SEL_MW_RD: req_n_o = !bus_rd_i && rd_avail;
      SEL_UD_WR: req_n_o = (wr_cnt_i < THRESH_C);
      SEL_UD_RD: begin
        burst_inc_o = req_q_i && bus_rd_i;
        // drop on the closing read of a burst or on an empty FIFO
        req_n_o     = rd_avail && !(burst_inc_o && burst_last_i);
      end
      default: req_n_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ide_dreq.sv
module ide_dreq
  import ide_dreq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH     = 8,
  parameter int unsigned UDMA_WR_THRESH = 4,
  parameter int unsigned UDMA_RD_BURST  = 4,
  localparam int unsigned CNT_W         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             dir_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic [CNT_W-1:0] rd_cnt_i,
  output logic             req_o
);
  xfer_sel_e sel;
  logic cfg_chg, req_q, req_rule, req_n, burst_inc, burst_last, burst_clr;

  ide_dreq_cfg_trk u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_i),
    .dir_i (dir_i),
    .sel_o (sel),
    .chg_o (cfg_chg)
  );

  ide_dreq_rules #(
    .CNT_W    (CNT_W),
    .DEPTH    (FIFO_DEPTH),
    .WR_THRESH(UDMA_WR_THRESH)
  ) u_rules (
    .sel_i       (sel),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .wr_cnt_i    (wr_cnt_i),
    .rd_cnt_i    (rd_cnt_i),
    .req_q_i     (req_q),
    .burst_last_i(burst_last),
    .req_n_o     (req_rule),
    .burst_inc_o (burst_inc)
  );

  assign req_n     = en_i && !cfg_chg && req_rule;
  // restart the burst on disable, reconfiguration or a fresh rise
  assign burst_clr = !en_i || cfg_chg || (req_n && !req_q);

  ide_dreq_burst #(.BURST(UDMA_RD_BURST)) u_burst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (burst_clr),
    .inc_i (burst_inc),
    .last_o(burst_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_n;
  end

  assign req_o = req_q;
endmodule

// File: rtl/ide_dreq_chk.sv
module ide_dreq_chk #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned WR_THRESH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             mode_i,
  input logic             dir_i,
  input logic             bus_wr_i,
  input logic             bus_rd_i,
  input logic [CNT_W-1:0] wr_cnt_i,
  input logic [CNT_W-1:0] rd_cnt_i,
  input logic             req_o
);
  localparam logic [CNT_W-1:0] THR_C = CNT_W'(WR_THRESH);
  logic       prev_v;
  logic [1:0] prev_cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_v   <= 1'b0;
      prev_cfg <= 2'b00;
    end else begin
      prev_v   <= 1'b1;
      prev_cfg <= {mode_i, dir_i};
    end
  end

  always_comb if (!rst_ni) AST_RST_LOW: assert (!req_o); // R1

  AST_DIS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !req_o); // R1
  AST_MW_WR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && dir_i && bus_wr_i) |=> !req_o); // R2
  AST_MW_RD_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !dir_i && bus_rd_i) |=> !req_o); // R3
  AST_UD_WR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && dir_i && wr_cnt_i >= THR_C) |=> !req_o); // R4
  AST_UD_RD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !dir_i && rd_cnt_i == '0) |=> !req_o); // R6
  AST_UD_RD_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !dir_i && !req_o && rd_cnt_i == '0) |=> !req_o); // R7
  AST_CFG_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_v && {mode_i, dir_i} != prev_cfg) |=> !req_o); // R8
endmodule

bind ide_dreq ide_dreq_chk #(
  .CNT_W    (CNT_W),
  .WR_THRESH(UDMA_WR_THRESH)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .mode_i  (mode_i),
  .dir_i   (dir_i),
  .bus_wr_i(bus_wr_i),
  .bus_rd_i(bus_rd_i),
  .wr_cnt_i(wr_cnt_i),
  .rd_cnt_i(rd_cnt_i),
  .req_o   (req_o)
);

// File: tb/ide_dreq_bench.sv
module ide_dreq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0, mode_i = 1'b0, dir_i = 1'b0;
  logic       bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [3:0] wr_cnt_i = '0, rd_cnt_i = '0;
  logic       req_o;

  typedef struct { bit exp; string tag; } exp_t;
  exp_t exp_q[$];
  exp_t item;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  // reference state
  bit       m_req = 0;
  bit [1:0] m_cfg = 2'b00;
  int       m_burst = 0;

  always #5 clk_i = ~clk_i;

  ide_dreq u_ide_dreq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i), .dir_i(dir_i),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .wr_cnt_i(wr_cnt_i),
    .rd_cnt_i(rd_cnt_i), .req_o(req_o)
  );

  task automatic check(bit act, bit exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: req_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: drive one cycle of inputs, push the expected request after the edge
  task automatic step(bit en, bit md, bit dr, bit wr, bit rd,
                      int wc, int rc, string tag);
    bit [1:0] cfg;
    bit chg, nreq;
    @(negedge clk_i);
    en_i = en; mode_i = md; dir_i = dr; bus_wr_i = wr; bus_rd_i = rd;
    wr_cnt_i = 4'(wc); rd_cnt_i = 4'(rc);
    cfg = {md, dr};
    chg = (cfg != m_cfg);
    if (!en || chg) nreq = 0;
    else case (cfg)
      2'b01: nreq = !wr && (wc < 8);                        // R2
      2'b00: nreq = !rd && (rc != 0);                       // R3
      2'b11: nreq = (wc < 4);                               // R4
      default: nreq = (rc != 0) && !(m_req && rd && m_burst == 3); // R5 R6
    endcase
    if (!en || chg)                  m_burst = 0;
    else if (nreq && !m_req)         m_burst = 0;           // R7
    else if (cfg == 2'b10 && m_req && rd) m_burst++;
    m_cfg = cfg;
    m_req = nreq;
    exp_q.push_back('{nreq, tag});
  endtask

  // monitor
  always @(posedge clk_i) begin
    #2;
    if (exp_q.size() > 0) begin
      item = exp_q.pop_front();
      check(req_o, item.exp, item.tag);
    end
  end

  initial begin
    #200_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: req_o=%0b expected completion", req_o);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rd_cnt_i = 4'd5; wr_cnt_i = 4'd1; en_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #2 check(req_o, 1'b0, "R1 reset");
    en_i = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;

    step(0, 0, 0, 0, 0, 0, 5, "R1 disabled");
    step(0, 0, 0, 0, 1, 1, 5, "R1 disabled");
    // multi-word write
    step(1, 0, 1, 0, 0, 2, 0, "R8 cfg change");
    step(1, 0, 1, 0, 0, 2, 0, "R2 room");
    step(1, 0, 1, 1, 0, 2, 0, "R2 write drop");
    step(1, 0, 1, 0, 0, 3, 0, "R2 reassert");
    step(1, 0, 1, 1, 0, 3, 0, "R2 write drop");
    step(1, 0, 1, 0, 0, 8, 0, "R2 full");
    step(1, 0, 1, 0, 0, 7, 0, "R2 room");
    // multi-word read
    step(1, 0, 0, 0, 0, 0, 3, "R8 cfg change");
    step(1, 0, 0, 0, 0, 0, 3, "R3 data");
    step(1, 0, 0, 0, 1, 0, 3, "R3 read drop");
    step(1, 0, 0, 0, 0, 0, 2, "R3 reassert");
    step(1, 0, 0, 0, 0, 0, 0, "R3 empty");
    // ultra write
    step(1, 1, 1, 0, 0, 0, 0, "R8 cfg change");
    step(1, 1, 1, 0, 0, 0, 0, "R4 level 0");
    step(1, 1, 1, 1, 0, 1, 0, "R4 write ignored");
    step(1, 1, 1, 1, 0, 3, 0, "R4 level 3");
    step(1, 1, 1, 0, 0, 4, 0, "R4 level 4");
    step(1, 1, 1, 0, 0, 5, 0, "R4 level 5");
    step(1, 1, 1, 1, 0, 3, 0, "R4 level 3");
    // ultra read
    step(1, 1, 0, 0, 0, 0, 8, "R8 cfg change");
    step(1, 1, 0, 0, 0, 0, 8, "R7 rise");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 1, 0, 8, "R5 burst");
    step(1, 1, 0, 0, 0, 0, 8, "R7 reassert");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 1, 0, 8, "R5 partial");
    step(1, 1, 0, 0, 0, 0, 0, "R6 empty");
    step(1, 1, 0, 0, 0, 0, 0, "R7 no rise empty");
    step(1, 1, 0, 0, 0, 0, 2, "R7 rise");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 1, 0, 2, "R7 count restarted");
    step(1, 1, 0, 0, 1, 0, 2, "R5 fourth read");
    step(1, 1, 0, 0, 0, 0, 5, "R7 reassert");
    step(1, 1, 0, 0, 1, 0, 5, "R5 one read");
    step(0, 1, 0, 0, 0, 0, 5, "R1 disable");
    step(1, 1, 0, 0, 0, 0, 5, "R1 reenable");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 1, 0, 5, "R1 count cleared");
    step(1, 1, 0, 0, 1, 0, 5, "R5 fourth read");
    step(1, 1, 0, 0, 0, 0, 5, "R7 reassert");
    step(1, 0, 0, 0, 0, 0, 5, "R8 change while high");
    step(1, 0, 0, 0, 0, 0, 5, "R3 data");

    repeat (2) @(posedge clk_i);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule